// File: doc/BRIEF.md
# Quadrature-capable 16-bit timer channel

This block is one channel of a general-purpose timer. A 16-bit counter advances either on ticks from a free-running internal divider, on edges of an external clock pin, or on the four edges of a quadrature signal pair. In quadrature mode the count follows the direction of motion, and that mode overrides whatever clock source the control register selects. Two compare registers, A and B, are checked against the counter. A match can clear the counter, sets a compare flag, and drives a single output pin. In normal mode the pin toggles on a match with A. In PWM mode a match with A sets the pin high and a match with B sets it low.

Software reaches the channel through a small register port with a combinational read path. There are five word addresses: 0 is the control register, 1 is the status register, 2 is the counter, 3 is compare register A and 4 is compare register B. Status flags follow a read-then-write-zero clearing rule. A flag-direction control bit chooses whether a downward wrap of the counter sets the overflow flag as well as an upward wrap.

The quadrature decoder is a four-state machine named by the last sampled input pair {a,b}: P00, P10, P11 and P01. The forward transitions are P00→P10, P10→P11, P11→P01 and P01→P00, and each one emits an up step. The reverse transitions are P00→P01, P01→P11, P11→P10 and P10→P00, and each one emits a down step. Staying in the same state emits no step. A jump to the diagonal state, where both inputs changed, emits no step, and the machine moves to the newly sampled state.

Top module: `qtimer_chan`

## Requirements
- R1: After reset the control register reads 0xFF00, the status register reads 0xFFF8, the counter reads 0 and `tio` is 0. Control bits 15:8 and status bits 15:3 always read 1, and writes to them have no effect. The control fields are: bit 0 quadrature mode, bit 1 flag direction, bit 2 PWM enable, bits 4:3 clear select, bits 7:5 clock source. The status fields are: bit 0 overflow, bit 1 match A, bit 2 match B.
- R2: With clock source 0, 1, 2 or 3 and quadrature mode off, the counter increments once every 1, 2, 4 or 8 clocks respectively.
- R3: With clock source 4, 5 or 6/7 and quadrature mode off, the counter increments on a rising edge, a falling edge or either edge of `ext_clk` respectively. The pin is seen through a two-flop synchronizer.
- R4: In quadrature mode, each synchronized change of exactly one input is one count. The count goes up when `ph_a` leads `ph_b` and down when `ph_b` leads `ph_a`. A change of both inputs at once is not counted.
- R5: In quadrature mode the clock source field has no effect: edges on `ext_clk` and divider ticks do not move the counter.
- R6: Clear select 01 resets the counter to 0, instead of stepping it, on a count event that occurs while the counter equals A. Clear select 10 does the same for B. Clear select 00 or 11 never clears. This also holds in quadrature mode.
- R7: A count event while the counter equals A sets status bit 1, and one while the counter equals B sets status bit 2. This holds in every mode.
- R8: With flag direction 0, a wrap from 0xFFFF to 0 or from 0 to 0xFFFF sets status bit 0. With flag direction 1, only the upward wrap sets it. This holds in every mode.
- R9: Writing 0 to a status bit clears it only if that bit has been read as 1 since the last status write. Writing 1 has no effect. A hardware set in the same cycle wins over the clear.
- R10: With PWM enabled, a match with A drives `tio` to 1 and a match with B drives it to 0. B wins if both match together.
- R11: With PWM disabled, `tio` toggles on each match with A.
- R12: Addresses 2, 3 and 4 read and write the counter, A and B. A counter write takes effect on the next clock edge and wins over a count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms status clearing) |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| ext_clk | input | 1 | External count clock pin |
| ph_a | input | 1 | Quadrature phase A |
| ph_b | input | 1 | Quadrature phase B |
| tio | output | 1 | Compare / PWM output |

## Verification
If the decoder state held the wrong input pair, the next valid quadrature edge would be counted in the wrong direction or not counted at all. The counter value read back exactly three clocks after that edge would then be off by one or two. A stale compare or clear decision shows up on the first count event at the compare value: `tio` fails to change, the matching status bit stays clear, or the counter runs past the compare value instead of returning to 0. A broken arm bit for flag clearing is seen on the very next status write, because the write either clears a flag that was never read or leaves set a flag that was read.

// File: rtl/qt_pkg.sv
package qt_pkg;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_CNT  = 2;
    localparam int ADDR_GRA  = 3;
    localparam int ADDR_GRB  = 4;

    localparam int CB_PHASE = 0;
    localparam int CB_FDIR  = 1;
    localparam int CB_PWM   = 2;
    localparam int CB_CLR   = 3;
    localparam int CB_SRC   = 5;
    localparam int CTRL_W   = 8;
    localparam int STAT_W   = 3;

    typedef enum logic [1:0] {
        P00 = 2'b00,
        P01 = 2'b01,
        P10 = 2'b10,
        P11 = 2'b11
    } qpos_t;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_OFF  = 2'b11
    } clr_sel_t;
endpackage

// File: rtl/qt_sync.sv
module qt_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[i] <= '0;
                else if (i == 0)
                    stage_q[i] <= d;
                else
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qt_quad_fsm.sv
module qt_quad_fsm
    import qt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pa,
    input  logic pb,
    output logic step,
    output logic up
);
    qpos_t state_q;
    qpos_t cur;

    assign cur = qpos_t'({pa, pb});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= P00;
        else
            state_q <= cur;
    end

    always_comb begin
        step = 1'b0;
        up   = 1'b0;
        unique case (state_q)
            P00: begin
                if (cur == P10) begin step = 1'b1; up = 1'b1; end
                else if (cur == P01) step = 1'b1;
            end
            P10: begin
                if (cur == P11) begin step = 1'b1; up = 1'b1; end
                else if (cur == P00) step = 1'b1;
            end
            P11: begin
                if (cur == P01) begin step = 1'b1; up = 1'b1; end
                else if (cur == P10) step = 1'b1;
            end
            P01: begin
                if (cur == P00) begin step = 1'b1; up = 1'b1; end
                else if (cur == P11) step = 1'b1;
            end
        endcase
    end

    AST_SINGLE_CHANGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($countones(cur ^ state_q) == 1)); // R4
endmodule

// File: rtl/qt_clk_sel.sv
module qt_clk_sel #(
    parameter int PW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src,
    input  logic       ext_s,
    output logic       tick
);
    logic [PW-1:0] div_q;
    logic [PW-1:0] low_mask;
    logic          ext_prev_q;
    logic          int_tick;
    logic          rise;
    logic          fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q      <= '0;
            ext_prev_q <= 1'b0;
        end else begin
            div_q      <= div_q + PW'(1);
            ext_prev_q <= ext_s;
        end
    end

    assign low_mask = (PW'(1) << src[1:0]) - PW'(1);
    assign int_tick = &(div_q | ~low_mask);
    assign rise     = ext_s & ~ext_prev_q;
    assign fall     = ~ext_s & ext_prev_q;

    always_comb begin
        if (!src[2])
            tick = int_tick;
        else if (src[1])
            tick = rise | fall;
        else if (src[0])
            tick = fall;
        else
            tick = rise;
    end
endmodule

// File: rtl/qtimer_chan.sv
module qtimer_chan
    import qt_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          ext_clk,
    input  logic          ph_a,
    input  logic          ph_b,
    output logic          tio
);
    localparam int CRSV = W - CTRL_W;
    localparam int SRSV = W - STAT_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [W-1:0]      cnt_q, gra_q, grb_q;
    logic [STAT_W-1:0] flag_q, arm_q, flag_set, flag_clr;
    logic              tio_q;

    logic [2:0] sync_q;
    logic       qd_step, qd_up, cs_tick;
    logic       phase_en, fdir, pwm_en;
    clr_sel_t   clr_sel;
    logic       tick, cnt_up, hit_a, hit_b, do_clr;
    logic       up_wrap, dn_wrap;
    logic       wr_ctrl, wr_stat, wr_cnt, wr_gra, wr_grb, rd_stat;

    qt_sync #(.STAGES(2), .W(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ext_clk, ph_a, ph_b}), .q(sync_q)
    );

    qt_quad_fsm u_quad (
        .clk(clk), .rst_n(rst_n), .pa(sync_q[1]), .pb(sync_q[0]),
        .step(qd_step), .up(qd_up)
    );

    qt_clk_sel #(.PW(3)) u_csel (
        .clk(clk), .rst_n(rst_n), .src(ctrl_q[CB_SRC +: 3]),
        .ext_s(sync_q[2]), .tick(cs_tick)
    );

    assign phase_en = ctrl_q[CB_PHASE];
    assign fdir     = ctrl_q[CB_FDIR];
    assign pwm_en   = ctrl_q[CB_PWM];
    assign clr_sel  = clr_sel_t'(ctrl_q[CB_CLR +: 2]);

    assign wr_ctrl = wr_en && (addr == AW'(ADDR_CTRL));
    assign wr_stat = wr_en && (addr == AW'(ADDR_STAT));
    assign wr_cnt  = wr_en && (addr == AW'(ADDR_CNT));
    assign wr_gra  = wr_en && (addr == AW'(ADDR_GRA));
    assign wr_grb  = wr_en && (addr == AW'(ADDR_GRB));
    assign rd_stat = rd_en && (addr == AW'(ADDR_STAT));

    // count event: quadrature overrides every clock-source selection
    assign tick   = phase_en ? qd_step : cs_tick;
    assign cnt_up = phase_en ? qd_up : 1'b1;
    assign hit_a  = tick && (cnt_q == gra_q);
    assign hit_b  = tick && (cnt_q == grb_q);

    always_comb begin
        unique case (clr_sel)
            CLR_ON_A:          do_clr = hit_a;
            CLR_ON_B:          do_clr = hit_b;
            CLR_NONE, CLR_OFF: do_clr = 1'b0;
        endcase
    end

    assign up_wrap  = tick && !do_clr && cnt_up && (cnt_q == '1);
    assign dn_wrap  = tick && !do_clr && !cnt_up && (cnt_q == '0);
    assign flag_set = {hit_b, hit_a, up_wrap | (dn_wrap & ~fdir)};
    assign flag_clr = {STAT_W{wr_stat}} & arm_q & ~wdata[STAT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            gra_q  <= '0;
            grb_q  <= '0;
            flag_q <= '0;
            arm_q  <= '0;
            tio_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
            if (wr_gra)  gra_q  <= wdata;
            if (wr_grb)  grb_q  <= wdata;

            if (wr_cnt)
                cnt_q <= wdata;
            else if (do_clr)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_up ? cnt_q + W'(1) : cnt_q - W'(1);

            flag_q <= flag_set | (flag_q & ~flag_clr);

            if (wr_stat)
                arm_q <= '0;
            else if (rd_stat)
                arm_q <= arm_q | flag_q;

            if (pwm_en) begin
                if (hit_b)      tio_q <= 1'b0;
                else if (hit_a) tio_q <= 1'b1;
            end else if (hit_a) begin
                tio_q <= ~tio_q;
            end
        end
    end

    always_comb begin
        case (addr)
            AW'(ADDR_CTRL): rdata = {{CRSV{1'b1}}, ctrl_q};
            AW'(ADDR_STAT): rdata = {{SRSV{1'b1}}, flag_q};
            AW'(ADDR_CNT):  rdata = cnt_q;
            AW'(ADDR_GRA):  rdata = gra_q;
            AW'(ADDR_GRB):  rdata = grb_q;
            default:        rdata = '0;
        endcase
    end

    assign tio = tio_q;

    AST_PHASE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en && !qd_step && !wr_cnt |=> $stable(cnt_q)); // R5
    AST_FDIR_NO_DOWN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        fdir && qd_step && !qd_up && phase_en && !flag_q[0] && (cnt_q == '0) |=> !flag_q[0]); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[0] && !wr_stat |=> flag_q[0]); // R9
    AST_PWM_HIGH_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en && hit_a && !hit_b |=> tio); // R10
    AST_PWM_LOW_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en && hit_b |=> !tio); // R10
endmodule

// File: tb/qtimer_chan_tb.sv
`timescale 1ns/1ps
module qtimer_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ext_clk = 1'b0, ph_a = 1'b0, ph_b = 1'b0;
    logic        tio;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] rv;
    logic        tio_before;

    always #10 clk = ~clk;

    qtimer_chan u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .ph_a(ph_a),
        .ph_b(ph_b), .tio(tio)
    );

    // {addr, write data, expected read-back}; R1 and R12
    localparam logic [34:0] VEC [8] = '{
        {3'd0, 16'h0000, 16'hFF00},
        {3'd0, 16'h00FF, 16'hFFFF},
        {3'd3, 16'hA5A5, 16'hA5A5},
        {3'd4, 16'h5A5A, 16'h5A5A},
        {3'd0, 16'h1280, 16'hFF80},
        {3'd3, 16'h0000, 16'h0000},
        {3'd4, 16'hFFFF, 16'hFFFF},
        {3'd2, 16'h1234, 16'h1234}
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic qstep(input logic a, input logic b);
        ph_a = a; ph_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic epulse();
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #4000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, sampled before the first active edge
        peek(3'd0, rv); check(rv == 16'hFF00, "R1 ctrl reset", rv, 16'hFF00);
        peek(3'd1, rv); check(rv == 16'hFFF8, "R1 status reset", rv, 16'hFFF8);
        peek(3'd2, rv); check(rv == 16'h0000, "R1 counter reset", rv, 16'h0000);
        check(tio == 1'b0, "R1 tio reset", 16'(tio), 16'h0);

        // register table walk (R1 reserved bits, R12 read/write)
        foreach (VEC[i]) begin
            bus_wr(VEC[i][34:32], VEC[i][31:16]);
            peek(VEC[i][34:32], rv);
            check(rv == VEC[i][15:0], "R1/R12 table", rv, VEC[i][15:0]);
        end

        // R12: counter write wins over a running count
        bus_wr(3'd0, 16'h0000);
        bus_wr(3'd2, 16'h4000);
        peek(3'd2, rv); check(rv == 16'h4000, "R12 write over tick", rv, 16'h4000);

        // R2: divide by 1 over 10 clocks
        bus_wr(3'd0, 16'h0080);
        bus_wr(3'd2, 16'h0000);
        bus_wr(3'd0, 16'h0000);
        repeat (10) @(posedge clk);
        @(negedge clk);
        peek(3'd2, rv); check(rv == 16'd10, "R2 div1", rv, 16'd10);

        // R2: divide by 8 over 64 clocks
        bus_wr(3'd0, 16'h0080);
        bus_wr(3'd2, 16'h0000);
        bus_wr(3'd0, 16'h0060);
        repeat (64) @(posedge clk);
        @(negedge clk);
        peek(3'd2, rv); check(rv == 16'd8, "R2 div8", rv, 16'd8);

        // R3: rising, falling, both edges of ext_clk
        bus_wr(3'd0, 16'h0080);
        bus_wr(3'd2, 16'h0000);
        epulse();
        peek(3'd2, rv); check(rv == 16'd1, "R3 rising", rv, 16'd1);
        bus_wr(3'd0, 16'h00A0);
        epulse();
        peek(3'd2, rv); check(rv == 16'd2, "R3 falling", rv, 16'd2);
        bus_wr(3'd0, 16'h00C0);
        epulse();
        peek(3'd2, rv); check(rv == 16'd4, "R3 both", rv, 16'd4);

        // R8: quadrature down wrap with flag direction 0 (GRA=0, GRB=FFFF)
        bus_wr(3'd0, 16'h0080);
        bus_rd(3'd1, rv);
        bus_wr(3'd1, 16'h0000);
        bus_wr(3'd2, 16'h0000);
        bus_wr(3'd0, 16'h0081);
        qstep(1'b0, 1'b1);
        peek(3'd2, rv); check(rv == 16'hFFFF, "R4 down step", rv, 16'hFFFF);
        peek(3'd1, rv); check(rv[0] == 1'b1, "R8 down wrap sets flag", rv, 16'h0001);

        // R9: write 0 without prior read leaves the flag; after read it clears
        bus_wr(3'd1, 16'h0000);
        peek(3'd1, rv); check(rv[0] == 1'b1, "R9 unarmed clear ignored", rv, 16'h0001);
        bus_rd(3'd1, rv);
        bus_wr(3'd1, 16'h0000);
        peek(3'd1, rv); check(rv[0] == 1'b0, "R9 armed clear", rv, 16'h0000);

        // R8: flag direction 1 ignores the down wrap
        bus_wr(3'd0, 16'h0083);
        qstep(1'b1, 1'b1);
        peek(3'd2, rv); check(rv == 16'hFFFE, "R4 down step 2", rv, 16'hFFFE);
        bus_wr(3'd2, 16'h0000);
        qstep(1'b1, 1'b0);
        peek(3'd2, rv); check(rv == 16'hFFFF, "R8 fdir1 count", rv, 16'hFFFF);
        peek(3'd1, rv); check(rv[0] == 1'b0, "R8 fdir1 no flag", rv, 16'h0000);

        // R4: four up steps, then an ignored double change, then one more up
        bus_wr(3'd2, 16'h0100);
        qstep(1'b1, 1'b1);
        qstep(1'b0, 1'b1);
        qstep(1'b0, 1'b0);
        qstep(1'b1, 1'b0);
        peek(3'd2, rv); check(rv == 16'h0104, "R4 four up edges", rv, 16'h0104);
        qstep(1'b0, 1'b1);
        peek(3'd2, rv); check(rv == 16'h0104, "R4 double change ignored", rv, 16'h0104);
        qstep(1'b0, 1'b0);
        peek(3'd2, rv); check(rv == 16'h0105, "R4 resume up", rv, 16'h0105);

        // R5: ext_clk edges ignored in quadrature mode
        epulse();
        peek(3'd2, rv); check(rv == 16'h0105, "R5 source ignored", rv, 16'h0105);

        // R6/R7/R11: clear on A in quadrature mode
        bus_wr(3'd3, 16'h0107);
        bus_wr(3'd0, 16'h0089);
        bus_rd(3'd1, rv);
        bus_wr(3'd1, 16'h0000);
        tio_before = tio;
        qstep(1'b1, 1'b0);
        qstep(1'b1, 1'b1);
        qstep(1'b0, 1'b1);
        peek(3'd2, rv); check(rv == 16'h0000, "R6 clear on A", rv, 16'h0000);
        peek(3'd1, rv); check(rv == 16'hFFFA, "R7 match A flag", rv, 16'hFFFA);
        check(tio == ~tio_before, "R11 toggle on A", 16'(tio), 16'(~tio_before));

        // R10: PWM with A=2, B=4 on ext rising edges
        bus_wr(3'd0, 16'h0084);
        bus_wr(3'd3, 16'h0002);
        bus_wr(3'd4, 16'h0004);
        bus_wr(3'd2, 16'h0000);
        repeat (3) epulse();
        check(tio == 1'b1, "R10 high after A", 16'(tio), 16'h1);
        epulse();
        check(tio == 1'b1, "R10 holds between", 16'(tio), 16'h1);
        epulse();
        check(tio == 1'b0, "R10 low after B", 16'(tio), 16'h0);
        peek(3'd2, rv); check(rv == 16'd5, "R10 count", rv, 16'd5);
        peek(3'd1, rv); check(rv[2] == 1'b1, "R7 match B flag", rv, 16'h0004);

        finish_run();
    end
endmodule